// File: doc/BRIEF.md
# Sequential Fixed-Point Matrix Multiply Engine

This block multiplies matrix A (rows x inner) by matrix B (inner x cols) where all three matrices live in one shared, synchronous, word-addressed memory. A caller writes the operands and an initial output buffer into memory. It then pulses `start` with the three runtime dimensions and three base addresses, and waits for the one-cycle `done` pulse. The engine has a single multiply-accumulate datapath and walks the loops one step at a time. The output row is the outer loop, the output column the middle loop and the inner reduction index the innermost loop.

The engine does not clear the output. For every output element it reads the value already stored, adds every product of the reduction into a 32-bit accumulator, and writes the element back exactly once. A caller that wants a plain product must therefore zero the output region first. A caller that pre-loads a bias or a partial sum gets it added in. Data words are signed Q8.8 fixed point. The written value is saturated to 16 bits.

Top module: `mm_engine`

## Requirements
- R1: All matrices are row-major: element (i,k) of A is read at base_a + cols_a*i + k, element (k,j) of B at base_b + cols_b*k + j, and element (i,j) of the output is read and written at base_c + cols_b*i + j.
- R2: Each output element (i,j) becomes its prior memory contents plus the sum over k of A(i,k)*B(k,j). It is written exactly once per job, so a job writes rows_a*cols_b words.
- R3: Words are signed 16-bit Q8.8. The prior output word is scaled by 256, and the 32-bit products are summed on top of it. The written word is that sum arithmetically shifted right by 8 (rounding toward minus infinity), then clamped to the range 0x8000 (-32768) to 0x7FFF (32767).
- R4: If rows_a, cols_a or cols_b is zero when a start is accepted, `done` is high in the very next cycle and no memory write occurs.
- R5: A `start` that arrives while `busy` is high is ignored: the running job finishes with its own dimensions and addresses, and the ignored request causes no memory access.
- R6: `done` is high for exactly one cycle per accepted start. `busy` is high from the cycle after an accepted start until and including the `done` cycle.
- R7: Read data is taken from `mem_rdata` one cycle after a cycle with `mem_re` high. `mem_re` and `mem_we` are never high in the same cycle.
- R8: After reset, `busy`, `done`, `mem_re` and `mem_we` are low.
- R9: Writes land only inside the output region base_c to base_c + rows_a*cols_b - 1. No other memory word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job when idle |
| rows_a | input | DIM_W | Rows of A and of the output |
| cols_a | input | DIM_W | Columns of A, rows of B (reduction length) |
| cols_b | input | DIM_W | Columns of B and of the output |
| base_a | input | AW | Word address of A(0,0) |
| base_b | input | AW | Word address of B(0,0) |
| base_c | input | AW | Word address of output (0,0) |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle job completion pulse |
| mem_addr | output | AW | Memory word address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after mem_re |

## Verification
Every combination of the three dimensions from 1 to 3 is run with pseudo-random operands and a non-zero pre-loaded output. A wrong index stride or a swapped loop order therefore shows up as wrong elements, and a cleared accumulator shows up as a lost pre-load. Hand-picked operands drive the sum past both 16-bit limits and put tiny negative values through the shift, which separates saturation and floor rounding from wrapping or truncation toward zero. Each dimension set to zero, and a second start fired in the middle of a job, show whether idle handling and busy gating leave memory untouched. A whole-memory comparison after every job catches stray writes.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int DATA_W = 16;
  localparam int ACC_W  = 32;
  localparam int FRAC_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_RDC, S_RDA, S_RDB, S_MAC, S_WR, S_DONE
  } mm_state_e;

  // Prior output word moved into accumulator scale (Q16.16)
  function automatic logic signed [ACC_W-1:0] acc_seed(input logic signed [DATA_W-1:0] c);
    return {{(ACC_W-DATA_W-FRAC_W){c[DATA_W-1]}}, c, {FRAC_W{1'b0}}};
  endfunction

  function automatic logic signed [ACC_W-1:0] acc_step(input logic signed [ACC_W-1:0] acc,
                                                       input logic signed [DATA_W-1:0] a,
                                                       input logic signed [DATA_W-1:0] b);
    logic signed [ACC_W-1:0] p;
    p = ACC_W'(a) * ACC_W'(b);
    return acc + p;
  endfunction

  // Shift back to Q8.8 (floor) and clamp to the word range
  function automatic logic signed [DATA_W-1:0] acc_to_word(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] s;
    s = acc >>> FRAC_W;
    if (s > ACC_W'(32767))       return 16'sh7FFF;
    else if (s < -ACC_W'(32768)) return 16'sh8000;
    else                         return s[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/mm_loop_ctr.sv
module mm_loop_ctr #(
  parameter int DIM_W = 8,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step_k,
  input  logic             step_elem,
  input  logic [DIM_W-1:0] n_rows,
  input  logic [DIM_W-1:0] n_inner,
  input  logic [DIM_W-1:0] n_cols,
  output logic             k_first,
  output logic             k_last,
  output logic             elem_last,
  output logic [AW-1:0]    a_off,
  output logic [AW-1:0]    b_off,
  output logic [AW-1:0]    c_off
);
  logic [DIM_W-1:0] i_q, j_q, k_q;
  logic [AW-1:0]    a_row_q, c_row_q, b_ptr_q;
  logic             j_last, i_last;

  assign k_first   = (k_q == '0);
  assign k_last    = (k_q == n_inner - 1'b1);
  assign j_last    = (j_q == n_cols - 1'b1);
  assign i_last    = (i_q == n_rows - 1'b1);
  assign elem_last = i_last && j_last;
  assign a_off     = a_row_q + AW'(k_q);
  assign b_off     = b_ptr_q;
  assign c_off     = c_row_q + AW'(j_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= '0; j_q <= '0; k_q <= '0;
      a_row_q <= '0; c_row_q <= '0; b_ptr_q <= '0;
    end else if (load) begin
      i_q <= '0; j_q <= '0; k_q <= '0;
      a_row_q <= '0; c_row_q <= '0; b_ptr_q <= '0;
    end else begin
      if (step_k) begin
        k_q     <= k_q + 1'b1;
        b_ptr_q <= b_ptr_q + AW'(n_cols);
      end
      if (step_elem) begin
        k_q <= '0;
        if (!j_last) begin
          j_q     <= j_q + 1'b1;
          b_ptr_q <= AW'(j_q + 1'b1);
        end else begin
          j_q     <= '0;
          b_ptr_q <= '0;
          i_q     <= i_q + 1'b1;
          a_row_q <= a_row_q + AW'(n_inner);
          c_row_q <= c_row_q + AW'(n_cols);
        end
      end
    end
  end
endmodule

// File: rtl/mm_mac.sv
module mm_mac
  import mm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     seed_c,
  input  logic                     grab_a,
  input  logic                     do_mac,
  input  logic signed [DATA_W-1:0] rdata,
  output logic signed [DATA_W-1:0] wb_word
);
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [DATA_W-1:0] a_q;

  assign wb_word = acc_to_word(acc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      a_q   <= '0;
    end else begin
      if (seed_c) acc_q <= acc_seed(rdata);
      if (grab_a) a_q   <= rdata;
      if (do_mac) acc_q <= acc_step(acc_q, a_q, rdata);
    end
  end
endmodule

// File: rtl/mm_engine.sv
module mm_engine
  import mm_pkg::*;
#(
  parameter int DIM_W = 8,
  parameter int AW    = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [DIM_W-1:0]         rows_a,
  input  logic [DIM_W-1:0]         cols_a,
  input  logic [DIM_W-1:0]         cols_b,
  input  logic [AW-1:0]            base_a,
  input  logic [AW-1:0]            base_b,
  input  logic [AW-1:0]            base_c,
  output logic                     busy,
  output logic                     done,
  output logic [AW-1:0]            mem_addr,
  output logic                     mem_re,
  output logic                     mem_we,
  output logic signed [DATA_W-1:0] mem_wdata,
  input  logic signed [DATA_W-1:0] mem_rdata
);
  mm_state_e        state_q, state_d;
  logic [DIM_W-1:0] cfg_rows, cfg_inner, cfg_cols;
  logic [AW-1:0]    cfg_base_a, cfg_base_b, cfg_base_c;
  logic [AW-1:0]    a_off, b_off, c_off;
  logic             k_first, k_last, elem_last;

  // Named events for assertions
  logic accept, zero_dim, step_k, step_elem;
  assign accept    = (state_q == S_IDLE) && start;
  assign zero_dim  = (rows_a == '0) || (cols_a == '0) || (cols_b == '0);
  assign step_k    = (state_q == S_MAC) && !k_last;
  assign step_elem = (state_q == S_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cfg_rows  <= '0; cfg_inner <= '0; cfg_cols <= '0;
      cfg_base_a <= '0; cfg_base_b <= '0; cfg_base_c <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cfg_rows   <= rows_a;  cfg_inner  <= cols_a;  cfg_cols   <= cols_b;
        cfg_base_a <= base_a;  cfg_base_b <= base_b;  cfg_base_c <= base_c;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start) state_d = zero_dim ? S_DONE : S_RDC;
      S_RDC:  state_d = S_RDA;
      S_RDA:  state_d = S_RDB;
      S_RDB:  state_d = S_MAC;
      S_MAC:  state_d = k_last ? S_WR : S_RDA;
      S_WR:   state_d = elem_last ? S_DONE : S_RDC;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      S_RDA:   mem_addr = cfg_base_a + a_off;
      S_RDB:   mem_addr = cfg_base_b + b_off;
      default: mem_addr = cfg_base_c + c_off;
    endcase
  end

  assign mem_re = (state_q == S_RDC) || (state_q == S_RDA) || (state_q == S_RDB);
  assign mem_we = (state_q == S_WR);
  assign busy   = (state_q != S_IDLE);
  assign done   = (state_q == S_DONE);

  mm_loop_ctr #(.DIM_W(DIM_W), .AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .step_k(step_k), .step_elem(step_elem),
    .n_rows(cfg_rows), .n_inner(cfg_inner), .n_cols(cfg_cols),
    .k_first(k_first), .k_last(k_last), .elem_last(elem_last),
    .a_off(a_off), .b_off(b_off), .c_off(c_off)
  );

  mm_mac u_mac (
    .clk(clk), .rst_n(rst_n),
    .seed_c((state_q == S_RDA) && k_first),
    .grab_a(state_q == S_RDB),
    .do_mac(state_q == S_MAC),
    .rdata(mem_rdata),
    .wb_word(mem_wdata)
  );

  logic [AW-1:0] wr_rel;
  assign wr_rel = mem_addr - cfg_base_c;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(mem_re && mem_we)); // R7
  AST_WR_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (32'(wr_rel) < 32'(cfg_rows) * 32'(cfg_cols))); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(cfg_rows) && $stable(cfg_inner) && $stable(cfg_cols) && $stable(cfg_base_c))); // R5
  AST_ZERO_DIM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && zero_dim) |=> (done && !mem_we)); // R4
  AST_WR_AFTER_MAC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(state_q) == S_MAC)); // R2
endmodule

// File: tb/mm_engine_test.sv
module mm_engine_test;
  localparam int DIM_W = 8;
  localparam int AW    = 12;
  localparam int MEM_N = 1024;
  localparam int LIMIT = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DIM_W-1:0] rows_a = '0, cols_a = '0, cols_b = '0;
  logic [AW-1:0] base_a = '0, base_b = '0, base_c = '0;
  logic busy, done, mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic signed [15:0] mem_wdata;
  logic signed [15:0] mem_rdata = '0;

  logic signed [15:0] mem  [0:MEM_N-1];
  logic signed [15:0] expm [0:MEM_N-1];
  int wr_count = 0;
  int overlap_count = 0;
  int n_tests = 0;
  int n_fail = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_we) begin
      mem[mem_addr[9:0]] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
    if (mem_re && mem_we) overlap_count <= overlap_count + 1;
  end

  mm_engine #(.DIM_W(DIM_W), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rows_a(rows_a), .cols_a(cols_a), .cols_b(cols_b),
    .base_a(base_a), .base_b(base_b), .base_c(base_c),
    .busy(busy), .done(done), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic signed [15:0] rnd_word();
    seed = seed * 32'd1103515245 + 32'd12345;
    return 16'(int'((seed >> 16) % 1024) - 512);
  endfunction

  task automatic fill_rand(input int base, input int n);
    for (int x = 0; x < n; x++) mem[base + x] = rnd_word();
  endtask

  // Reference model: floor division by 256 and clamping, written from the spec
  task automatic build_expect(input int ra, input int ca, input int cb,
                              input int ba, input int bb, input int bc);
    for (int x = 0; x < MEM_N; x++) expm[x] = mem[x];
    for (int i = 0; i < ra; i++)
      for (int j = 0; j < cb; j++) begin
        longint acc, q;
        acc = longint'(mem[bc + cb*i + j]) * 256;
        for (int k = 0; k < ca; k++)
          acc += longint'(mem[ba + ca*i + k]) * longint'(mem[bb + cb*k + j]);
        q = acc / 256;
        if (acc < 0 && (acc % 256) != 0) q = q - 1;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        expm[bc + cb*i + j] = 16'(q);
      end
  endtask

  task automatic launch(input int ra, input int ca, input int cb,
                        input int ba, input int bb, input int bc);
    @(negedge clk);
    rows_a = DIM_W'(ra); cols_a = DIM_W'(ca); cols_b = DIM_W'(cb);
    base_a = AW'(ba); base_b = AW'(bb); base_c = AW'(bc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) check(1'b0, "R6", "watchdog expired waiting for done", cyc, LIMIT);
  endtask

  task automatic compare_mem(input string req, input int bc, input int n_out);
    int bad_other;
    bad_other = 0;
    for (int x = 0; x < MEM_N; x++) begin
      if (x >= bc && x < bc + n_out)
        check(mem[x] === expm[x], req, $sformatf("output word %0d", x - bc), mem[x], expm[x]);
      else if (mem[x] !== expm[x]) bad_other++;
    end
    check(bad_other == 0, "R9", "words changed outside output region", bad_other, 0);
  endtask

  task automatic job(input string req, input int ra, input int ca, input int cb);
    int cyc, w0;
    build_expect(ra, ca, cb, 0, 100, 200);
    w0 = wr_count;
    launch(ra, ca, cb, 0, 100, 200);
    check(busy === 1'b1, "R6", "busy after accepted start", busy, 1);
    wait_done(cyc);
    @(negedge clk);
    check(done === 1'b0, "R6", "done lasts one cycle", done, 0);
    check(wr_count - w0 == ra*cb, "R2", "one write per output element", wr_count - w0, ra*cb);
    compare_mem(req, 200, ra*cb);
  endtask

  initial begin
    for (int x = 0; x < MEM_N; x++) mem[x] = 16'(x * 7 - 300);
    repeat (3) @(negedge clk);
    // R8: reset state
    check(busy === 1'b0, "R8", "busy in reset", busy, 0);
    check(done === 1'b0, "R8", "done in reset", done, 0);
    check(mem_re === 1'b0 && mem_we === 1'b0, "R8", "memory strobes in reset", {mem_re, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 sweep: every dimension triple in 1..3 with non-zero pre-loaded output
    for (int ra = 1; ra <= 3; ra++)
      for (int ca = 1; ca <= 3; ca++)
        for (int cb = 1; cb <= 3; cb++) begin
          fill_rand(0, ra*ca);
          fill_rand(100, ca*cb);
          fill_rand(200, ra*cb);
          job("R1", ra, ca, cb);
        end

    // R3: positive saturation (127.0 * 127.0 summed twice)
    mem[0] = 16'sh7F00; mem[1] = 16'sh7F00; mem[100] = 16'sh7F00; mem[101] = 16'sh7F00;
    mem[200] = 16'sh0100;
    job("R3", 1, 2, 1);
    check(mem[200] === 16'sh7FFF, "R3", "positive clamp", mem[200], 32767);

    // R3: negative saturation (-128.0 * 127.0 summed twice)
    mem[0] = 16'sh8000; mem[1] = 16'sh8000; mem[100] = 16'sh7F00; mem[101] = 16'sh7F00;
    mem[200] = 16'sh0000;
    job("R3", 1, 2, 1);
    check(mem[200] === 16'sh8000, "R3", "negative clamp", mem[200], -32768);

    // R3: floor rounding of sub-LSB results: +1/65536 -> 0, -1/65536 -> -1 LSB
    mem[0] = 16'sh0001; mem[100] = 16'sh0001; mem[101] = 16'sh0001; mem[200] = 16'sh0000; mem[201] = 16'sh0000;
    mem[1] = 16'sh0000;
    job("R3", 1, 1, 2);
    check(mem[200] === 16'sh0000, "R3", "tiny positive floors to zero", mem[200], 0);
    mem[0] = 16'shFFFF; mem[200] = 16'sh0000; mem[201] = 16'sh0000;
    job("R3", 1, 1, 2);
    check(mem[200] === 16'shFFFF, "R3", "tiny negative floors to -1", mem[200], -1);

    // R4: each dimension zero
    for (int z = 0; z < 3; z++) begin
      int w0;
      build_expect(0, 0, 0, 0, 100, 200);
      w0 = wr_count;
      launch(z == 0 ? 0 : 2, z == 1 ? 0 : 2, z == 2 ? 0 : 2, 0, 100, 200);
      check(done === 1'b1, "R4", $sformatf("done next cycle, zero dim %0d", z), done, 1);
      @(negedge clk);
      check(wr_count == w0, "R4", "no writes on zero dimension", wr_count - w0, 0);
      compare_mem("R4", 200, 0);
    end

    // R5: second start while busy is ignored
    begin
      int cyc, w0;
      fill_rand(0, 6); fill_rand(100, 6); fill_rand(200, 4);
      build_expect(2, 3, 2, 0, 100, 200);
      w0 = wr_count;
      launch(2, 3, 2, 0, 100, 200);
      repeat (4) @(negedge clk);
      rows_a = 8'd3; cols_a = 8'd1; cols_b = 8'd3; base_c = 12'd500;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(cyc);
      @(negedge clk);
      @(negedge clk);
      check(busy === 1'b0, "R5", "idle after job, late start not taken", busy, 0);
      check(wr_count - w0 == 4, "R5", "writes of running job only", wr_count - w0, 4);
      compare_mem("R5", 200, 4);
    end

    // R7: no cycle with both strobes
    check(overlap_count == 0, "R7", "read and write in same cycle", overlap_count, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule